// File: doc/BRIEF.md
# Depth-First Bus Number Enumerator

This engine walks a tree of buses, bridges and endpoints depth-first and gives every bridge its bus numbers. A probe port asks about one bus/device/function address. The answer comes back later and says three things: whether a function is present there, whether that function is a bridge, and, for function 0, whether the device has more than one function. The engine then issues register writes. Each write carries the bridge's address together with its upstream (primary) bus, its downstream (secondary) bus and the last bus reachable through it (subordinate).

Every bridge is written twice. The first write opens it with a placeholder subordinate of 0xFF, which lets the scan go on beneath it. The second write closes it with the real subordinate once everything below it has been numbered. A small stack stores where the parent scan stopped, so the engine can resume there after closing a bridge. When the scan of bus 0 finishes, a done flag rises and the highest assigned bus number is available. The engine stops with an error flag if it runs out of bus numbers or out of stack levels.

Top module: `bus_enum_engine`

## Requirements
- R1: After reset, done, error and highest-bus outputs are 0, and neither probe_valid nor wr_valid is asserted. A start pulse begins the scan, and its first probe is bus 0, device 0, function 0.
- R2: Within a bus, probes go in ascending device order and, within a device, ascending function order. Functions 1 to 7 are probed only when function 0 is present with its multi-function bit set. When function 0 is absent, the rest of that device is skipped.
- R3: When a bridge is found, one write goes out with primary = bus being scanned, secondary = next free bus number and subordinate = 0xFF. The next free number is 1 after start and rises by 1 for each bridge.
- R4: After a bridge's opening write, the next probe is (its secondary, 0, 0). The parent bus resumes at the following position only after that bridge's closing write.
- R5: When the scan of a bridge's secondary bus ends, a closing write goes to the same bridge address with the same primary and secondary. Its subordinate is the highest bus number assigned so far, so a bridge with no bridges below it gets subordinate = secondary.
- R6: Every ancestor closed on the way back up gets the same subordinate as its descendants closed just before it.
- R7: No function is probed twice in one scan. Endpoints consume no bus number.
- R8: The probe address is held while probe_valid is high and probe_ready is low. The write fields are held while wr_valid is high and wr_ready is low. A response is taken only after its probe was accepted.
- R9: When the scan of bus 0 ends, done is set and max_bus shows the highest assigned bus. After that, no probe or write is issued until the next start.
- R10: If a bridge is found when the next free bus number would exceed 255, the engine makes no write for it, sets the error flag and sets done.
- R11: If a bridge is found while STACK_DEPTH bridges are already open, the engine makes no write for it, sets the error flag and sets done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a new scan (taken when idle or done) |
| probe_valid | output | 1 | Probe request pending |
| probe_ready | input | 1 | Probe request accepted |
| probe_bus | output | 8 | Probed bus |
| probe_dev | output | 5 | Probed device |
| probe_fn | output | 3 | Probed function |
| rsp_valid | input | 1 | Probe answer strobe |
| rsp_present | input | 1 | A function exists at the probed address |
| rsp_bridge | input | 1 | The function is a bridge |
| rsp_multi | input | 1 | Device has several functions (meaningful for function 0) |
| wr_valid | output | 1 | Bridge write pending |
| wr_ready | input | 1 | Bridge write accepted |
| wr_bus | output | 8 | Bridge bus address |
| wr_dev | output | 5 | Bridge device address |
| wr_fn | output | 3 | Bridge function address |
| wr_pri | output | 8 | Primary bus value |
| wr_sec | output | 8 | Secondary bus value |
| wr_sub | output | 8 | Subordinate bus value |
| done | output | 1 | Scan finished (normally or on error) |
| overflow | output | 1 | Scan stopped for lack of bus numbers or stack levels |
| max_bus | output | 8 | Highest bus number assigned |

## Verification
The bench covers a nested switch tree that has an endpoint next to bridges, a leaf bridge and a bridge on function 2 of a multi-function device. It also places a phantom bridge on function 1 of a single-function device. An engine that skipped the patch-up on the way back would leave ancestors with 0xFF or with their own secondary as subordinate. An engine that ignored the multi-function bit would probe the phantom and number a bus that does not exist. A chain exactly STACK_DEPTH deep must finish cleanly, and one level more must stop with the error flag. A design with an off-by-one in the stack-full test would either corrupt its return path or stop one level too early. A flat bus of 256 bridges drains every bus number: the engine must close bridge 255 with subordinate 255, refuse the last bridge, and not wrap to bus 0.

// File: rtl/bus_enum_pkg.sv
package bus_enum_pkg;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;

  typedef logic [BUS_W-1:0] bus_t;
  typedef logic [DEV_W-1:0] dev_t;
  typedef logic [FN_W-1:0]  fn_t;

  // Saved scan position of a parent bus while a bridge below it is open.
  typedef struct packed {
    bus_t bus;
    dev_t dev;
    fn_t  fn;
    logic multi;
  } frame_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PROBE, S_WAIT, S_STEP, S_OPEN, S_CLOSE, S_DONE
  } state_t;

  typedef struct packed {
    dev_t dev;
    fn_t  fn;
    logic wrap;   // bus exhausted
  } pos_t;

  // Next probe position after (dev, fn). A device is left after function 0
  // unless it is multi-function, and after its last function otherwise.
  function automatic pos_t next_pos(dev_t dev, fn_t fn, logic multi);
    pos_t p;
    if ((fn == '0 && !multi) || fn == '1) begin
      p.dev  = dev + 1'b1;
      p.fn   = '0;
      p.wrap = (dev == '1);
    end else begin
      p.dev  = dev;
      p.fn   = fn + 1'b1;
      p.wrap = 1'b0;
    end
    return p;
  endfunction
endpackage

// File: rtl/bus_enum_alloc.sv
module bus_enum_alloc #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  output logic [BW-1:0] next_sec,
  output logic [BW-1:0] highest,
  output logic          exhausted
);
  // One extra bit so running past the last bus number is visible.
  logic [BW:0] nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     nxt <= (BW+1)'(1);
    else if (clear) nxt <= (BW+1)'(1);
    else if (take)  nxt <= nxt + 1'b1;
  end

  assign next_sec  = nxt[BW-1:0];
  assign highest   = BW'(nxt - 1'b1);
  assign exhausted = nxt[BW];
endmodule

// File: rtl/bus_enum_stack.sv
module bus_enum_stack
  import bus_enum_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   push,
  input  logic   pop,
  input  frame_t din,
  output frame_t top,
  output logic   full,
  output logic   empty
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] sp;
  logic [PTR_W-1:0] sp_m1;
  frame_t           mem [DEPTH];

  assign sp_m1 = sp - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp <= '0;
    else if (clear) sp <= '0;
    else if (push)  sp <= sp + 1'b1;
    else if (pop)   sp <= sp_m1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[sp[IDX_W-1:0]] <= din;
  end

  assign top   = mem[sp_m1[IDX_W-1:0]];
  assign full  = (sp == PTR_W'(DEPTH));
  assign empty = (sp == '0);
endmodule

// File: rtl/bus_enum_engine.sv
module bus_enum_engine
  import bus_enum_pkg::*;
#(
  parameter int STACK_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             probe_valid,
  input  logic             probe_ready,
  output logic [BUS_W-1:0] probe_bus,
  output logic [DEV_W-1:0] probe_dev,
  output logic [FN_W-1:0]  probe_fn,
  input  logic             rsp_valid,
  input  logic             rsp_present,
  input  logic             rsp_bridge,
  input  logic             rsp_multi,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [BUS_W-1:0] wr_bus,
  output logic [DEV_W-1:0] wr_dev,
  output logic [FN_W-1:0]  wr_fn,
  output logic [BUS_W-1:0] wr_pri,
  output logic [BUS_W-1:0] wr_sec,
  output logic [BUS_W-1:0] wr_sub,
  output logic             done,
  output logic             overflow,
  output logic [BUS_W-1:0] max_bus
);
  localparam bus_t SUB_OPEN = '1;

  state_t state;
  bus_t   cur_bus;
  dev_t   dev;
  fn_t    fn;
  logic   cur_multi;
  logic   err_q;

  // Named events for the checker.
  logic   begin_scan;
  logic   open_fire;
  logic   close_fire;
  logic   bridge_seen;
  logic   refuse;

  bus_t   new_sec;
  bus_t   highest;
  logic   exhausted;
  frame_t stk_top;
  logic   stk_full;
  logic   stk_empty;
  pos_t   adv;

  assign begin_scan  = start && (state == S_IDLE || state == S_DONE);
  assign open_fire   = (state == S_OPEN) && wr_ready;
  assign close_fire  = (state == S_CLOSE) && wr_ready;
  assign bridge_seen = (state == S_WAIT) && rsp_valid && rsp_present && rsp_bridge;
  assign refuse      = bridge_seen && (exhausted || stk_full);
  assign adv         = next_pos(dev, fn, cur_multi);

  bus_enum_alloc #(.BW(BUS_W)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (begin_scan),
    .take      (open_fire),
    .next_sec  (new_sec),
    .highest   (highest),
    .exhausted (exhausted)
  );

  bus_enum_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (begin_scan),
    .push  (open_fire),
    .pop   (close_fire),
    .din   ('{bus: cur_bus, dev: dev, fn: fn, multi: cur_multi}),
    .top   (stk_top),
    .full  (stk_full),
    .empty (stk_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_bus   <= '0;
      dev       <= '0;
      fn        <= '0;
      cur_multi <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE, S_DONE: begin
          if (begin_scan) begin
            state     <= S_PROBE;
            cur_bus   <= '0;
            dev       <= '0;
            fn        <= '0;
            cur_multi <= 1'b0;
            err_q     <= 1'b0;
          end
        end
        S_PROBE: begin
          if (probe_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (rsp_valid) begin
            if (fn == '0) cur_multi <= rsp_present && rsp_multi;
            if (refuse) begin
              err_q <= 1'b1;
              state <= S_DONE;
            end else if (bridge_seen) begin
              state <= S_OPEN;
            end else begin
              state <= S_STEP;
            end
          end
        end
        S_STEP: begin
          if (adv.wrap) begin
            state <= stk_empty ? S_DONE : S_CLOSE;
          end else begin
            dev   <= adv.dev;
            fn    <= adv.fn;
            state <= S_PROBE;
          end
        end
        S_OPEN: begin
          if (wr_ready) begin
            cur_bus   <= new_sec;
            dev       <= '0;
            fn        <= '0;
            cur_multi <= 1'b0;
            state     <= S_PROBE;
          end
        end
        S_CLOSE: begin
          if (wr_ready) begin
            cur_bus   <= stk_top.bus;
            dev       <= stk_top.dev;
            fn        <= stk_top.fn;
            cur_multi <= stk_top.multi;
            state     <= S_STEP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign probe_valid = (state == S_PROBE);
  assign probe_bus   = cur_bus;
  assign probe_dev   = dev;
  assign probe_fn    = fn;

  always_comb begin
    wr_valid = (state == S_OPEN) || (state == S_CLOSE);
    if (state == S_CLOSE) begin
      wr_bus = stk_top.bus;
      wr_dev = stk_top.dev;
      wr_fn  = stk_top.fn;
      wr_pri = stk_top.bus;
      wr_sec = cur_bus;
      wr_sub = highest;
    end else begin
      wr_bus = cur_bus;
      wr_dev = dev;
      wr_fn  = fn;
      wr_pri = cur_bus;
      wr_sec = new_sec;
      wr_sub = SUB_OPEN;
    end
  end

  assign done     = (state == S_DONE);
  assign overflow = err_q;
  assign max_bus  = highest;
endmodule

// File: rtl/bus_enum_checker.sv
module bus_enum_checker
  import bus_enum_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       probe_valid,
  input logic       probe_ready,
  input logic [BUS_W-1:0] probe_bus,
  input logic [DEV_W-1:0] probe_dev,
  input logic [FN_W-1:0]  probe_fn,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [BUS_W-1:0] wr_bus,
  input logic [DEV_W-1:0] wr_dev,
  input logic [FN_W-1:0]  wr_fn,
  input logic [BUS_W-1:0] wr_pri,
  input logic [BUS_W-1:0] wr_sec,
  input logic [BUS_W-1:0] wr_sub,
  input logic       done,
  input logic       overflow,
  input logic [BUS_W-1:0] max_bus,
  input logic       open_fire,
  input logic       close_fire
);
  AST_PROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid && !probe_ready |=> probe_valid && $stable({probe_bus, probe_dev, probe_fn})); // R8
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable({wr_bus, wr_dev, wr_fn, wr_pri, wr_sec, wr_sub})); // R8
  AST_OPEN_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    open_fire |-> wr_sub == '1 && wr_sec == BUS_W'(max_bus + 1'b1)); // R3
  AST_MAX_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> max_bus >= $past(max_bus)); // R3
  AST_CLOSE_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    close_fire |-> wr_sub == max_bus); // R5
  AST_CLOSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    close_fire |-> wr_sec <= wr_sub && wr_pri < wr_sec); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !probe_valid && !wr_valid); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> done); // R10
endmodule

bind bus_enum_engine bus_enum_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .probe_valid(probe_valid),
  .probe_ready(probe_ready),
  .probe_bus  (probe_bus),
  .probe_dev  (probe_dev),
  .probe_fn   (probe_fn),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_bus     (wr_bus),
  .wr_dev     (wr_dev),
  .wr_fn      (wr_fn),
  .wr_pri     (wr_pri),
  .wr_sec     (wr_sec),
  .wr_sub     (wr_sub),
  .done       (done),
  .overflow   (overflow),
  .max_bus    (max_bus),
  .open_fire  (open_fire),
  .close_fire (close_fire)
);

// File: tb/bus_enum_engine_bench.sv
module bus_enum_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 60000;
  localparam int N_EXP      = 12;

  // {bus, dev, fn, pri, sec, sub}, one byte each, for the nested tree.
  localparam logic [47:0] EXP_WR [N_EXP] = '{
    48'h00_01_00_00_01_FF, 48'h01_00_00_01_02_FF, 48'h02_00_00_02_03_FF,
    48'h02_00_00_02_03_03, 48'h02_01_00_02_04_FF, 48'h02_01_00_02_04_04,
    48'h01_00_00_01_02_04, 48'h00_01_00_00_01_04, 48'h00_02_00_00_05_FF,
    48'h00_02_00_00_05_05, 48'h00_03_02_00_06_FF, 48'h00_03_02_00_06_06
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       probe_valid, probe_ready;
  logic [7:0] probe_bus;
  logic [4:0] probe_dev;
  logic [2:0] probe_fn;
  logic       rsp_valid, rsp_present, rsp_bridge, rsp_multi;
  logic       wr_valid, wr_ready;
  logic [7:0] wr_bus, wr_pri, wr_sec, wr_sub;
  logic [4:0] wr_dev;
  logic [2:0] wr_fn;
  logic       done, overflow;
  logic [7:0] max_bus;

  int         n_checks = 0;
  int         n_fail   = 0;
  int         mode     = 0;
  int         chain_len = 0;
  int         probe_cnt, wr_cnt, dup_cnt, hold_err;
  logic       ghost_hit;
  logic [15:0] first_probe;
  logic [47:0] got_wr [16];
  logic [47:0] last_wr;
  logic       seen [2048];

  bus_enum_engine u_bus_enum_engine (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Topology: returns {present, bridge, multi}.
  function automatic logic [2:0] topo(logic [7:0] b, logic [4:0] d, logic [2:0] f);
    logic [2:0] r = 3'b000;
    if (mode == 0) begin
      if (b == 0) begin
        if (d == 0 && f == 0) r = 3'b100;
        if (d == 1 && f == 0) r = 3'b110;
        if (d == 2 && f == 0) r = 3'b110;
        if (d == 3 && f == 0) r = 3'b101;
        if (d == 3 && f == 2) r = 3'b110;
        if (d == 4 && f == 0) r = 3'b100;
        if (d == 4 && f == 1) r = 3'b110;   // phantom: device 4 is single-function
      end
      if (b == 1 && d == 0 && f == 0) r = 3'b110;
      if (b == 2 && d <= 1 && f == 0) r = 3'b110;
      if ((b == 3 || b == 4) && d == 0 && f == 0) r = 3'b100;
    end else if (mode == 1) begin
      if (int'(b) < chain_len && d == 0 && f == 0) r = 3'b110;
    end else begin
      if (b == 0) r = (f == 0) ? 3'b111 : 3'b110;
    end
    return r;
  endfunction

  // Probe responder and write sink, driven away from the active edge.
  initial begin
    logic       pend = 1'b0;
    int         dly = 0;
    int         cyc = 0;
    logic [7:0] pb = '0;
    logic [4:0] pd = '0;
    logic [2:0] pf = '0;
    logic [2:0] t;
    logic       pv_stall = 1'b0, wv_stall = 1'b0;
    logic [15:0] p_prev = '0;
    logic [47:0] w_prev = '0;
    probe_ready = 1'b0; wr_ready = 1'b0;
    rsp_valid = 1'b0; rsp_present = 1'b0; rsp_bridge = 1'b0; rsp_multi = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = 1'b0;
      if (!rst_n) begin
        pend = 1'b0; pv_stall = 1'b0; wv_stall = 1'b0;
      end else begin
        if (pv_stall && (!probe_valid || {probe_bus, probe_dev, probe_fn} != p_prev)) hold_err++;
        if (wv_stall && (!wr_valid ||
            {wr_bus, 3'b0, wr_dev, 5'b0, wr_fn, wr_pri, wr_sec, wr_sub} != w_prev)) hold_err++;
        if (pend) begin
          if (dly == 0) begin
            t = topo(pb, pd, pf);
            rsp_valid = 1'b1; rsp_present = t[2]; rsp_bridge = t[1]; rsp_multi = t[0];
            pend = 1'b0;
          end else dly--;
        end
        probe_ready = (cyc % 3) != 1;
        wr_ready    = (cyc % 4) != 2;
        pv_stall = probe_valid && !probe_ready;
        p_prev   = {probe_bus, probe_dev, probe_fn};
        wv_stall = wr_valid && !wr_ready;
        w_prev   = {wr_bus, 3'b0, wr_dev, 5'b0, wr_fn, wr_pri, wr_sec, wr_sub};
        if (probe_valid && probe_ready) begin
          pend = 1'b1; dly = cyc % 3;
          pb = probe_bus; pd = probe_dev; pf = probe_fn;
          if (probe_cnt == 0) first_probe = {probe_bus, probe_dev, probe_fn};
          probe_cnt++;
          if (probe_bus < 8) begin
            if (seen[{probe_bus[2:0], probe_dev, probe_fn}]) dup_cnt++;
            seen[{probe_bus[2:0], probe_dev, probe_fn}] = 1'b1;
          end
          if (mode == 0 && probe_bus == 0 && probe_dev == 4 && probe_fn == 1) ghost_hit = 1'b1;
        end
        if (wr_valid && wr_ready) begin
          last_wr = {wr_bus, 3'b0, wr_dev, 5'b0, wr_fn, wr_pri, wr_sec, wr_sub};
          if (wr_cnt < 16) got_wr[wr_cnt] = last_wr;
          wr_cnt++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    probe_cnt = 0; wr_cnt = 0; dup_cnt = 0; hold_err = 0; ghost_hit = 1'b0;
    first_probe = '1; last_wr = '0;
    for (int i = 0; i < 2048; i++) seen[i] = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_scan(input int m, input int len);
    int n = 0;
    mode = m; chain_len = len;
    do_reset();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < WAIT_LIMIT) begin
      @(negedge clk);
      n++;
    end
    check(done, "R9", "watchdog / done", done, 1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    // Reset state
    do_reset();
    check(!done && !overflow, "R1", "done/error after reset", {done, overflow}, 0);
    check(max_bus == 0, "R1", "max_bus after reset", max_bus, 0);
    check(!probe_valid && !wr_valid, "R1", "idle handshakes", {probe_valid, wr_valid}, 0);

    // Nested tree, walked against the expected write table
    run_scan(0, 0);
    check(first_probe == 16'h0000, "R1", "first probe", first_probe, 0);
    check(wr_cnt == N_EXP, "R4", "write count", wr_cnt, N_EXP);
    for (int i = 0; i < N_EXP; i++) begin
      if (EXP_WR[i][7:0] == 8'hFF)
        check(got_wr[i] == EXP_WR[i], "R3", $sformatf("open write %0d", i), got_wr[i], EXP_WR[i]);
      else if (EXP_WR[i][7:0] == EXP_WR[i][15:8])
        check(got_wr[i] == EXP_WR[i], "R5", $sformatf("leaf close %0d", i), got_wr[i], EXP_WR[i]);
      else
        check(got_wr[i] == EXP_WR[i], "R6", $sformatf("ancestor close %0d", i), got_wr[i], EXP_WR[i]);
    end
    check(probe_cnt == 231, "R2", "probe count", probe_cnt, 231);
    check(!ghost_hit, "R2", "single-function device fn1 probed", ghost_hit, 0);
    check(dup_cnt == 0, "R7", "repeated probes", dup_cnt, 0);
    check(max_bus == 6 && !overflow, "R7", "highest bus", {overflow, max_bus}, 6);
    check(hold_err == 0, "R8", "handshake hold violations", hold_err, 0);
    repeat (10) @(negedge clk);
    check(wr_cnt == N_EXP && probe_cnt == 231 && done, "R9", "quiet after done",
          wr_cnt, N_EXP);

    // Chain exactly as deep as the stack
    run_scan(1, 8);
    check(wr_cnt == 16 && !overflow, "R11", "full-depth chain writes", wr_cnt, 16);
    check(got_wr[7] == 48'h07_00_00_07_08_FF, "R4", "deepest open", got_wr[7], 48'h07_00_00_07_08_FF);
    check(got_wr[8] == 48'h07_00_00_07_08_08, "R5", "deepest close", got_wr[8], 48'h07_00_00_07_08_08);
    check(last_wr == 48'h00_00_00_00_01_08, "R6", "root bridge close", last_wr, 48'h00_00_00_00_01_08);
    check(probe_cnt == 288, "R4", "chain probe count", probe_cnt, 288);

    // One level deeper than the stack
    run_scan(1, 9);
    check(overflow && done, "R11", "stack exhausted flag", {overflow, done}, 3);
    check(wr_cnt == 8 && max_bus == 8, "R11", "writes before stop", {wr_cnt[7:0], max_bus}, 16'h0808);

    // Flat bus of 256 bridges: bus numbers run out
    run_scan(2, 0);
    check(overflow && done, "R10", "bus numbers exhausted flag", {overflow, done}, 3);
    check(wr_cnt == 510, "R10", "write count", wr_cnt, 510);
    check(max_bus == 8'd255, "R10", "max_bus", max_bus, 255);
    check(last_wr == 48'h00_1F_06_00_FF_FF, "R10", "last close", last_wr, 48'h00_1F_06_00_FF_FF);
    check(hold_err == 0, "R8", "handshake hold violations (flat)", hold_err, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule